// File: doc/BRIEF.md
# Multiprocessor interrupt distributor

This block is the shared, global half of an interrupt controller for a cluster of CPUs. It watches a set of external interrupt lines. Interrupt IDs for these lines start at 32, and line index `i` carries ID `32 + i`. Each line is sampled through a two-stage synchronizer and judged against its own programmable trigger mode: active-high level, active-low level, rising edge or falling edge. Level sources are pending for as long as their active level is present. Edge sources latch a pending bit that stays set until a CPU reports that it has finished with that ID.

Each line has a routing register. When bit 31 of that register is set, the line is delivered only to the CPU named in its low bits. When bit 31 is clear, the line is delivered to every CPU. A routing register of zero therefore means "all CPUs". No other subset of CPUs can be selected. Each CPU sees one output: a valid flag plus the ID of the lowest-numbered pending interrupt routed to it. That CPU reports completion on a matching done port.

Software programs the block through a plain register port. Every request is accepted at once. Reads answer one cycle later. The port reaches a control register holding the global enable, the packed trigger-mode words and one routing register per line.

Top module: `mp_irq_dist`

## Requirements
- R1: After reset, no CPU output is valid, the distributor is disabled, every trigger mode is 0 (level-high) and every routing register reads 0 (all CPUs).
- R2: Bit 0 of the register at offset 0x000 is the global enable. While it is 0, no CPU output is valid and no edge is captured. Setting it back to 1 restores delivery of level sources that are still active.
- R3: The 2-bit trigger mode of line `i` sits in the word at offset 0x100 + 4*(2i/32), at bit 2i mod 32. Writes to that word set these fields, and reads return them. Reads of a word past the last trigger word return 0.
- R4: Mode 0 is level-high and mode 1 is level-low. Such a line is pending while its synchronized input holds the active level. It stops being pending when the level is removed.
- R5: Mode 2 captures a rising edge and mode 3 captures a falling edge. The pending bit stays set after the input returns to its idle level. An edge in the other direction is ignored.
- R6: A captured edge is cleared when a CPU that is a target of the line pulses its done-valid input with done-ID = 32 + i. A done pulse from a CPU that is not a target has no effect.
- R7: The routing register of line `i` is at offset 0x1000 + 4i. If bit 31 is set, only the CPU numbered in bits [1:0] receives the line. If bit 31 is clear (including the value 0), every CPU receives it.
- R8: Each CPU output presents the lowest-index pending line routed to it, as ID = 32 + index.
- R9: Every request is accepted. A read returns data on rd_data with rd_valid high exactly one cycle later. Routing reads return bit 31 and the CPU bits. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NIRQ | Raw shared interrupt lines, index i carries ID 32+i |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| cpu_irq_valid | output | NCPU | Per-CPU interrupt pending |
| cpu_irq_id | output | NCPU*ID_W | Per-CPU pending ID, CPU c in bits [c*ID_W +: ID_W] |
| cpu_done_valid | input | NCPU | Per-CPU completion pulse |
| cpu_done_id | input | NCPU*ID_W | Per-CPU completed ID, same packing as cpu_irq_id |

## Verification
A table runs each of the four trigger modes with chosen start and end input levels and chosen routing values. It shows that level sources follow the input, that edges are captured only in their own direction and are held, and that single-target routing reaches only the named CPU while routing value 0 reaches all. Directed sequences follow. They pulse an edge line and then complete it from a CPU that is not a target and from one that is, which separates route-aware clearing from clearing by any CPU. They raise two level lines together to show lowest-index priority. They toggle the enable, with an edge arriving while the block is disabled, to show that nothing is captured in that state. Register reads check the packed trigger layout, routing readback and unmapped offsets.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'd0,
    TRIG_LVL_LO = 2'd1,
    TRIG_RISE   = 2'd2,
    TRIG_FALL   = 2'd3
  } trig_e;

  // Word holding the 2-bit mode field of line idx
  function automatic int trig_word(int idx);
    return (2 * idx) / 32;
  endfunction

  // Bit position of that field inside its word
  function automatic int trig_lsb(int idx);
    return (2 * idx) % 32;
  endfunction

  function automatic logic is_edge_mode(logic [1:0] mode);
    return mode[1];
  endfunction

  function automatic logic level_active(logic [1:0] mode, logic cur);
    return (mode == TRIG_LVL_LO) ? ~cur : cur;
  endfunction

  function automatic logic edge_seen(logic [1:0] mode, logic cur, logic prv);
    case (mode)
      TRIG_RISE: return cur & ~prv;
      TRIG_FALL: return ~cur & prv;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mpd_regs.sv
module mpd_regs import mpd_pkg::*; #(
  parameter int NIRQ   = 32,
  parameter int NCPU   = 4,
  parameter int ADDR_W = 16,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int NTW   = (2 * NIRQ + 31) / 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wdata,
  output logic                       rd_valid,
  output logic [31:0]                rd_data,
  output logic                       dist_en,
  output logic [NIRQ-1:0][1:0]       trig_mode,
  output logic [NIRQ-1:0]            route_one,
  output logic [NIRQ-1:0][CPU_W-1:0] route_cpu
);

  localparam logic [ADDR_W-1:0] A_TRIG_LO = ADDR_W'(256);
  localparam logic [ADDR_W-1:0] A_TRIG_HI = ADDR_W'(256 + 4 * NTW);
  localparam logic [ADDR_W-1:0] A_RT_LO   = ADDR_W'(4096);
  localparam logic [ADDR_W-1:0] A_RT_HI   = ADDR_W'(4096 + 4 * NIRQ);

  logic              hit_ctrl, hit_trig, hit_route;
  logic [ADDR_W-1:0] trig_off, route_off;
  int                trig_wi, route_i;
  logic [31:0]       rword;

  assign hit_ctrl  = (addr == '0);
  assign hit_trig  = (addr >= A_TRIG_LO) && (addr < A_TRIG_HI);
  assign hit_route = (addr >= A_RT_LO) && (addr < A_RT_HI);
  assign trig_off  = addr - A_TRIG_LO;
  assign route_off = addr - A_RT_LO;
  assign trig_wi   = int'(trig_off[ADDR_W-1:2]);
  assign route_i   = int'(route_off[ADDR_W-1:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_en   <= 1'b0;
      trig_mode <= '0;
      route_one <= '0;
      route_cpu <= '0;
    end else if (wr_en) begin
      if (hit_ctrl) dist_en <= wdata[0];
      for (int i = 0; i < NIRQ; i++) begin
        if (hit_trig && trig_wi == trig_word(i))
          trig_mode[i] <= wdata[trig_lsb(i) +: 2];
        if (hit_route && route_i == i) begin
          route_one[i] <= wdata[31];
          route_cpu[i] <= wdata[CPU_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rword = '0;
    if (hit_ctrl) rword[0] = dist_en;
    for (int i = 0; i < NIRQ; i++) begin
      if (hit_trig && trig_wi == trig_word(i))
        rword[trig_lsb(i) +: 2] = trig_mode[i];
      if (hit_route && route_i == i) begin
        rword[31]        = route_one[i];
        rword[CPU_W-1:0] = route_cpu[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rword : '0;
    end
  end

endmodule

// File: rtl/mpd_src.sv
module mpd_src import mpd_pkg::*; #(
  parameter int NIRQ = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIRQ-1:0]      irq_raw,
  input  logic [NIRQ-1:0][1:0] trig_mode,
  input  logic                 dist_en,
  input  logic [NIRQ-1:0]      clr,
  output logic [NIRQ-1:0]      pend,
  output logic [NIRQ-1:0]      edge_hit,
  output logic [NIRQ-1:0]      edge_latch
);

  logic [NIRQ-1:0] sync1, sync2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= irq_raw;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_src
    assign edge_hit[i] = dist_en && edge_seen(trig_mode[i], sync2[i], prev[i]);

    // a new edge wins over a completion in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           edge_latch[i] <= 1'b0;
      else if (edge_hit[i]) edge_latch[i] <= 1'b1;
      else if (clr[i])      edge_latch[i] <= 1'b0;
    end

    assign pend[i] = is_edge_mode(trig_mode[i]) ? edge_latch[i]
                                                : level_active(trig_mode[i], sync2[i]);
  end

endmodule

// File: rtl/mpd_pick.sv
module mpd_pick #(
  parameter int NIRQ     = 32,
  parameter int ID_W     = 8,
  parameter int FIRST_ID = 32,
  localparam int IDX_W   = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic [NIRQ-1:0] mask,
  output logic            valid,
  output logic [ID_W-1:0] id
);

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (mask[i]) idx = IDX_W'(i);
  end

  assign valid = |mask;
  assign id    = ID_W'(idx) + ID_W'(FIRST_ID);

endmodule

// File: rtl/mp_irq_dist.sv
module mp_irq_dist #(
  parameter int NCPU     = 4,
  parameter int NIRQ     = 32,
  parameter int FIRST_ID = 32,
  parameter int ID_W     = 8,
  parameter int ADDR_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIRQ-1:0]      irq_in,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  output logic [NCPU-1:0]      cpu_irq_valid,
  output logic [NCPU*ID_W-1:0] cpu_irq_id,
  input  logic [NCPU-1:0]      cpu_done_valid,
  input  logic [NCPU*ID_W-1:0] cpu_done_id
);

  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic                       dist_en;
  logic [NIRQ-1:0][1:0]       trig_mode;
  logic [NIRQ-1:0]            route_one;
  logic [NIRQ-1:0][CPU_W-1:0] route_cpu;
  logic [NIRQ-1:0]            pend, edge_hit, edge_latch, clr;
  logic [NCPU-1:0][NIRQ-1:0]  route_hit;

  assign req_ready = 1'b1;

  mpd_regs #(.NIRQ(NIRQ), .NCPU(NCPU), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (req_valid && req_write),
    .rd_en     (req_valid && !req_write),
    .addr      (req_addr),
    .wdata     (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .dist_en   (dist_en),
    .trig_mode (trig_mode),
    .route_one (route_one),
    .route_cpu (route_cpu)
  );

  mpd_src #(.NIRQ(NIRQ)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_raw    (irq_in),
    .trig_mode  (trig_mode),
    .dist_en    (dist_en),
    .clr        (clr),
    .pend       (pend),
    .edge_hit   (edge_hit),
    .edge_latch (edge_latch)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar i = 0; i < NIRQ; i++) begin : g_rt
      assign route_hit[c][i] = !route_one[i] || (route_cpu[i] == CPU_W'(c));
    end

    mpd_pick #(.NIRQ(NIRQ), .ID_W(ID_W), .FIRST_ID(FIRST_ID)) u_pick (
      .mask  (pend & route_hit[c] & {NIRQ{dist_en}}),
      .valid (cpu_irq_valid[c]),
      .id    (cpu_irq_id[c*ID_W +: ID_W])
    );
  end

  // completion from a CPU that the line targets
  always_comb begin
    clr = '0;
    for (int i = 0; i < NIRQ; i++)
      for (int c = 0; c < NCPU; c++)
        if (cpu_done_valid[c] && route_hit[c][i] &&
            cpu_done_id[c*ID_W +: ID_W] == ID_W'(FIRST_ID + i))
          clr[i] = 1'b1;
  end

endmodule

// File: rtl/mpd_chk.sv
module mpd_chk #(
  parameter int NCPU     = 4,
  parameter int NIRQ     = 32,
  parameter int FIRST_ID = 32,
  parameter int ID_W     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dist_en,
  input logic [NIRQ-1:0]      edge_hit,
  input logic [NIRQ-1:0]      edge_latch,
  input logic [NIRQ-1:0]      clr,
  input logic [NCPU-1:0]      cpu_irq_valid,
  input logic [NCPU*ID_W-1:0] cpu_irq_id,
  input logic                 req_valid,
  input logic                 req_write,
  input logic                 rd_valid
);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dist_en |-> cpu_irq_valid == '0);

  // R5
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((edge_latch & $past(edge_hit)) == $past(edge_hit)));

  // R6
  latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(edge_latch) & ~edge_latch & ~$past(clr)) == '0));

  // R9
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  // R9
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);

  for (genvar c = 0; c < NCPU; c++) begin : g_id
    // R8
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_valid[c] |-> (cpu_irq_id[c*ID_W +: ID_W] >= ID_W'(FIRST_ID)) &&
                           (cpu_irq_id[c*ID_W +: ID_W] <  ID_W'(FIRST_ID + NIRQ)));
  end

endmodule

bind mp_irq_dist mpd_chk #(.NCPU(NCPU), .NIRQ(NIRQ), .FIRST_ID(FIRST_ID), .ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dist_en       (dist_en),
  .edge_hit      (edge_hit),
  .edge_latch    (edge_latch),
  .clr           (clr),
  .cpu_irq_valid (cpu_irq_valid),
  .cpu_irq_id    (cpu_irq_id),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .rd_valid      (rd_valid)
);

// File: tb/mp_irq_dist_bench.sv
`timescale 1ns/1ps
module mp_irq_dist_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  cpu_irq_valid;
  logic [31:0] cpu_irq_id;
  logic [3:0]  cpu_done_valid = '0;
  logic [31:0] cpu_done_id = '0;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mp_irq_dist u_mp_irq_dist (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .cpu_irq_valid(cpu_irq_valid), .cpu_irq_id(cpu_irq_id),
    .cpu_done_valid(cpu_done_valid), .cpu_done_id(cpu_done_id)
  );

  // {idx[4:0], mode[1:0], route[31:0], start level, end level, expected CPU mask[3:0]}
  localparam logic [44:0] VEC [0:6] = '{
    {5'd3,  2'd0, 32'h0000_0000, 1'b0, 1'b1, 4'b1111},
    {5'd7,  2'd1, 32'h8000_0002, 1'b1, 1'b0, 4'b0100},
    {5'd10, 2'd2, 32'h8000_0001, 1'b0, 1'b1, 4'b0010},
    {5'd20, 2'd3, 32'h8000_0003, 1'b1, 1'b0, 4'b1000},
    {5'd31, 2'd0, 32'h8000_0000, 1'b1, 1'b0, 4'b0000},
    {5'd5,  2'd3, 32'h0000_0000, 1'b0, 1'b0, 4'b0000},
    {5'd12, 2'd2, 32'h0000_0000, 1'b1, 1'b0, 4'b0000}
  };

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic done(int c, int id);
    @(negedge clk);
    cpu_done_valid[c] = 1'b1; cpu_done_id[c*8 +: 8] = 8'(id);
    @(negedge clk);
    cpu_done_valid = '0;
  endtask

  function automatic logic [15:0] trig_addr(int idx);
    return 16'(256 + 4 * ((idx * 2) >> 5));
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    check("R1 valid", 32'(cpu_irq_valid), 32'h0);
    rd(16'h0000, d, v);          check("R1 ctrl", d, 32'h0);
    rd(16'h1000 + 16'd8, d, v);  check("R1 route", d, 32'h0);
    rd(16'h0100, d, v);          check("R1 trig", d, 32'h0);

    // R3 packed trigger layout
    wr(16'h0104, 32'hFFFF_FFFF);
    rd(16'h0104, d, v);  check("R3 word1", d, 32'hFFFF_FFFF);
    rd(16'h0108, d, v);  check("R3 past end", d, 32'h0);
    wr(16'h0104, 32'h0);
    wr(16'h0100, 32'h0000_00C0);
    rd(16'h0100, d, v);  check("R3 idx3 field", d, 32'h0000_00C0);
    wr(16'h0100, 32'h0);

    wr(16'h0000, 32'h1);

    // table: trigger modes x routing (R4 R5 R7)
    for (int k = 0; k < 7; k++) begin
      logic [44:0] t = VEC[k];
      int idx = int'(t[44:40]);
      string tag = (t[39:38] < 2) ? "R4 R7 vec" : "R5 R7 vec";
      irq_in[idx] = t[5];
      cyc(4);
      wr(trig_addr(idx), 32'(t[39:38]) << ((idx * 2) % 32));
      wr(16'(4096 + 4 * idx), t[37:6]);
      cyc(1);
      irq_in[idx] = t[4];
      cyc(5);
      check(tag, 32'(cpu_irq_valid), 32'(t[3:0]));
      for (int c = 0; c < 4; c++)
        if (t[c]) check("R8 vec id", 32'(cpu_irq_id[c*8 +: 8]), 32'(idx + 32));
      irq_in[idx] = 1'b0;
      wr(trig_addr(idx), 32'h0);
      for (int c = 0; c < 4; c++) done(c, idx + 32);
      cyc(4);
      check("R6 vec cleanup", 32'(cpu_irq_valid), 32'h0);
    end

    // R5 held edge, R6 completion by any CPU when routed to all
    wr(16'h0100, 32'h2 << 18);
    irq_in[9] = 1'b1; cyc(4); irq_in[9] = 1'b0; cyc(5);
    check("R5 held", 32'(cpu_irq_valid), 32'hF);
    check("R8 id41", 32'(cpu_irq_id[8 +: 8]), 32'd41);
    done(1, 41); cyc(2);
    check("R6 all-route clear", 32'(cpu_irq_valid), 32'h0);

    // R6 single target: non-target completion ignored
    wr(16'h1000 + 16'd36, 32'h8000_0002);
    irq_in[9] = 1'b1; cyc(4); irq_in[9] = 1'b0; cyc(5);
    check("R7 single", 32'(cpu_irq_valid), 32'h4);
    done(0, 41); cyc(2);
    check("R6 non-target ignored", 32'(cpu_irq_valid), 32'h4);
    done(2, 41); cyc(2);
    check("R6 target clears", 32'(cpu_irq_valid), 32'h0);
    wr(16'h1000 + 16'd36, 32'h0);

    // R8 lowest index wins
    irq_in[4] = 1'b1; irq_in[6] = 1'b1; cyc(5);
    check("R8 low cpu0", 32'(cpu_irq_id[0 +: 8]), 32'd36);
    check("R8 low cpu3", 32'(cpu_irq_id[24 +: 8]), 32'd36);
    irq_in[4] = 1'b0; cyc(4);
    check("R8 next", 32'(cpu_irq_id[16 +: 8]), 32'd38);

    // R2 enable gating
    wr(16'h0000, 32'h0); cyc(1);
    check("R2 disabled", 32'(cpu_irq_valid), 32'h0);
    wr(16'h0000, 32'h1); cyc(1);
    check("R2 re-enabled", 32'(cpu_irq_valid), 32'hF);
    irq_in[6] = 1'b0; cyc(4);
    wr(16'h0000, 32'h0);
    irq_in[9] = 1'b1; cyc(4); irq_in[9] = 1'b0; cyc(4);
    wr(16'h0000, 32'h1); cyc(3);
    check("R2 no capture while off", 32'(cpu_irq_valid), 32'h0);

    // R9 register port
    check("R9 ready", 32'(req_ready), 32'h1);
    wr(16'h1000 + 16'd24, 32'h8000_0003);
    rd(16'h1000 + 16'd24, d, v);
    check("R9 route readback", d, 32'h8000_0003);
    check("R9 rd_valid", 32'(v), 32'h1);
    rd(16'h0200, d, v);
    check("R9 unmapped", d, 32'h0);
    rd(16'h0100, d, v);
    check("R3 idx9 field", d, 32'h0008_0000);
    cyc(1);
    check("R9 rd_valid drops", 32'(rd_valid), 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule